// File: doc/BRIEF.md
# Pin-Change and External Interrupt Controller

This block is the interrupt front end of a small 8-bit controller. It watches eleven input pins for any level change and collects those changes into one shared pin-change flag. Two group-enable bits gate whether a change may set that flag at all. Pins 3..0 form the first group and pins 10..4 form the second. A per-pin alternate-function input removes any single pin from detection. A separate external interrupt input has four sensing modes and sets its own flag in the three edge modes.

The core sees two registers through a small write/read port, a flag register and a mask register. Flags clear when software writes a one to their bit, or when the core acknowledges the matching vector. The block presents a registered request with a vector number. Vector 1 is the external input and vector 2 is the pin-change flag. All requests are gated by a global interrupt enable input.

Top module: `pcx_irq_ctrl`

## Requirements
- R1: Pin index 3..0 belong to group 0, enabled by mask-register bit 4. Pin index 10..4 belong to group 1, enabled by mask-register bit 5. Any level change on a pin whose group is enabled sets the pin-change flag, which is flag-register bit 5.
- R2: While a pin's group enable is 0, a change on that pin does not set the pin-change flag.
- R3: While `altfn_i[i]` is 1, a change on pin i does not set the pin-change flag.
- R4: `ext_mode_i` selects the external sensing mode: 00 is low level, 01 is any edge, 10 is falling edge and 11 is rising edge. In the three edge modes a matching edge sets the external flag, which is flag-register bit 6.
- R5: In low-level mode the external flag is held at 0, and any flag already set is cleared on the next clock. In this mode the external request is active while the synchronized input is low and the external enable is set.
- R6: Address 0 is the flag register and address 1 is the mask register. A write of a one to bit 6 or bit 5 of the flag register clears that flag. A write of zero leaves the flag unchanged. A mask write stores bits 6 (external enable), 5 and 4.
- R7: When `ack_i` is high, the flag of the vector given by `ack_vec_i` is cleared (1 clears the external flag, 2 clears the pin-change flag).
- R8: If a new qualifying event and a clear (by write or by acknowledge) fall in the same cycle, the flag ends up set.
- R9: `req_o` requires `gie_i`. The external request needs mask bit 6. The pin-change request needs the pin-change flag and at least one group enable. `vec_o` is 1 when the external request is active, 2 when only the pin-change request is active, and 0 when there is no request.
- R10: The flag register, the mask register, `rdata_o`, `req_o` and `vec_o` are all 0 after reset. Bits 7 and 3..0 of both registers always read as 0.
- R11: A change at a pin sets its flag on the third rising edge after it is applied. `rdata_o` (which shows the register addressed in the previous cycle) and `req_o` reflect it on the fourth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 11 | Monitored pins |
| altfn_i | input | 11 | Per-pin alternate-function mask, 1 excludes the pin |
| ext_i | input | 1 | External interrupt input |
| ext_mode_i | input | 2 | External sensing mode |
| gie_i | input | 1 | Global interrupt enable |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 flags, 1 mask |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data of the selected register |
| ack_i | input | 1 | Core takes a vector |
| ack_vec_i | input | 2 | Vector being taken |
| req_o | output | 1 | Interrupt request |
| vec_o | output | 2 | Requested vector, 0 when idle |

## Verification
A pin or external edge passes two synchronizer stages before it can be compared. The flag therefore changes on the third edge after the input moves, and `req_o` and `rdata_o` change on the fourth. The bench drives inputs on falling edges and reads four rising edges later, on the falling edge that follows. A write or acknowledge acts on the edge that samples it, and its effect is read one edge after that. For the same-cycle set-and-clear case, the write is timed so that it is sampled on exactly the third edge after the pin toggle.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int DW       = 8;
  localparam int FLG_EXT  = 6;
  localparam int FLG_PC   = 5;
  localparam int MSK_EXT  = 6;
  localparam int MSK_G1   = 5;
  localparam int MSK_G0   = 4;
  localparam logic [1:0] VEC_NONE = 2'd0;
  localparam logic [1:0] VEC_EXT  = 2'd1;
  localparam logic [1:0] VEC_PC   = 2'd2;

  typedef enum logic [1:0] {
    EXT_LOW  = 2'b00,
    EXT_ANY  = 2'b01,
    EXT_FALL = 2'b10,
    EXT_RISE = 2'b11
  } ext_mode_e;
endpackage

// File: rtl/pcx_sync.sv
module pcx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0]             prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg  <= '0;
      prev <= '0;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      prev <= stg[STAGES-1];
    end
  end

  assign q_o    = stg[STAGES-1];
  assign prev_o = prev;
endmodule

// File: rtl/pcx_ext_detect.sv
module pcx_ext_detect
  import pcx_pkg::*;
(
  input  ext_mode_e mode_i,
  input  logic      cur_i,
  input  logic      prev_i,
  output logic      evt_o,
  output logic      low_o
);
  always_comb begin
    unique case (mode_i)
      EXT_ANY:  evt_o = cur_i ^ prev_i;
      EXT_FALL: evt_o = ~cur_i & prev_i;
      EXT_RISE: evt_o = cur_i & ~prev_i;
      default:  evt_o = 1'b0;
    endcase
  end

  assign low_o = (mode_i == EXT_LOW) & ~cur_i;
endmodule

// File: rtl/pcx_flag.sv
module pcx_flag (
  input  logic clk,
  input  logic rst,
  input  logic force0_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst || force0_i) q_o <= 1'b0;
    else if (set_i)      q_o <= 1'b1;
    else if (clr_i)      q_o <= 1'b0;
  end
endmodule

// File: rtl/pcx_irq_ctrl.sv
module pcx_irq_ctrl
  import pcx_pkg::*;
#(
  parameter int N_PINS      = 11,
  parameter int N_GRP0      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] altfn_i,
  input  logic              ext_i,
  input  logic [1:0]        ext_mode_i,
  input  logic              gie_i,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              ack_i,
  input  logic [1:0]        ack_vec_i,
  output logic              req_o,
  output logic [1:0]        vec_o
);
  localparam logic ADDR_FLAG = 1'b0;
  localparam logic ADDR_MASK = 1'b1;

  logic [N_PINS-1:0] pin_s, pin_p, pin_qual;
  logic [0:0]        ext_s, ext_p;
  logic              en_ext, en_g1, en_g0;
  logic              pc_flag, ext_flag, pc_set, ext_set, pc_clr, ext_clr;
  logic              ext_low, lvl_mode, wr_flag, wr_mask;
  logic              ext_want, pc_want;
  ext_mode_e         mode;
  logic              unused_wbits;

  assign mode         = ext_mode_e'(ext_mode_i);
  assign lvl_mode     = (mode == EXT_LOW);
  assign wr_flag      = wr_i & (addr_i == ADDR_FLAG);
  assign wr_mask      = wr_i & (addr_i == ADDR_MASK);
  assign unused_wbits = ^{wdata_i[7], wdata_i[3:0]};

  pcx_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_s), .prev_o(pin_p)
  );

  pcx_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .d_i(ext_i), .q_o(ext_s), .prev_o(ext_p)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    if (i < N_GRP0) begin : g_grp0
      assign pin_qual[i] = (pin_s[i] ^ pin_p[i]) & ~altfn_i[i] & en_g0;
    end else begin : g_grp1
      assign pin_qual[i] = (pin_s[i] ^ pin_p[i]) & ~altfn_i[i] & en_g1;
    end
  end

  assign pc_set = |pin_qual;

  pcx_ext_detect u_ext_det (
    .mode_i(mode), .cur_i(ext_s[0]), .prev_i(ext_p[0]),
    .evt_o(ext_set), .low_o(ext_low)
  );

  assign pc_clr  = (wr_flag & wdata_i[FLG_PC])  | (ack_i & (ack_vec_i == VEC_PC));
  assign ext_clr = (wr_flag & wdata_i[FLG_EXT]) | (ack_i & (ack_vec_i == VEC_EXT));

  pcx_flag u_pc_flag (
    .clk(clk), .rst(rst), .force0_i(1'b0),
    .set_i(pc_set), .clr_i(pc_clr), .q_o(pc_flag)
  );

  pcx_flag u_ext_flag (
    .clk(clk), .rst(rst), .force0_i(lvl_mode),
    .set_i(ext_set), .clr_i(ext_clr), .q_o(ext_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_ext <= 1'b0;
      en_g1  <= 1'b0;
      en_g0  <= 1'b0;
    end else if (wr_mask) begin
      en_ext <= wdata_i[MSK_EXT];
      en_g1  <= wdata_i[MSK_G1];
      en_g0  <= wdata_i[MSK_G0];
    end
  end

  assign ext_want = en_ext & (lvl_mode ? ext_low : ext_flag);
  assign pc_want  = (en_g0 | en_g1) & pc_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o   <= 1'b0;
      vec_o   <= VEC_NONE;
      rdata_o <= '0;
    end else begin
      req_o <= gie_i & (ext_want | pc_want);
      if (!gie_i)        vec_o <= VEC_NONE;
      else if (ext_want) vec_o <= VEC_EXT;
      else if (pc_want)  vec_o <= VEC_PC;
      else               vec_o <= VEC_NONE;
      if (addr_i == ADDR_MASK) rdata_o <= {1'b0, en_ext, en_g1, en_g0, 4'b0000};
      else                     rdata_o <= {1'b0, ext_flag, pc_flag, 5'b00000};
    end
  end
endmodule

// File: rtl/pcx_irq_chk.sv
module pcx_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       gie_i,
  input logic [1:0] ext_mode_i,
  input logic       wr_i,
  input logic       addr_i,
  input logic [7:0] wdata_i,
  input logic       ack_i,
  input logic [1:0] ack_vec_i,
  input logic [7:0] rdata_o,
  input logic       req_o,
  input logic [1:0] vec_o,
  input logic       pc_flag,
  input logic       ext_flag,
  input logic       pc_set,
  input logic       ext_set
);
  p_rsv_zero_r10: assert property (@(posedge clk) disable iff (rst)
    rdata_o[7] == 1'b0 && rdata_o[3:0] == 4'b0000);

  p_lvl_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ext_mode_i == 2'b00 |=> !ext_flag);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    pc_set |=> pc_flag);

  p_ext_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    ext_set && ext_mode_i != 2'b00 |=> ext_flag);

  p_w1c_pc_r6: assert property (@(posedge clk) disable iff (rst)
    wr_i && !addr_i && wdata_i[5] && !pc_set |=> !pc_flag);

  p_w0_keep_r6: assert property (@(posedge clk) disable iff (rst)
    wr_i && !addr_i && !wdata_i[5] && !ack_i && pc_flag |=> pc_flag);

  p_ack_pc_r7: assert property (@(posedge clk) disable iff (rst)
    ack_i && ack_vec_i == 2'd2 && !pc_set |=> !pc_flag);

  p_ack_ext_r7: assert property (@(posedge clk) disable iff (rst)
    ack_i && ack_vec_i == 2'd1 && !ext_set |=> !ext_flag);

  p_gie_r9: assert property (@(posedge clk) disable iff (rst)
    !gie_i |=> !req_o);

  p_vec_valid_r9: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (vec_o == 2'd1 || vec_o == 2'd2));

  p_vec_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !req_o |-> vec_o == 2'd0);
endmodule

bind pcx_irq_ctrl pcx_irq_chk u_chk (
  .clk(clk), .rst(rst), .gie_i(gie_i), .ext_mode_i(ext_mode_i),
  .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .ack_i(ack_i),
  .ack_vec_i(ack_vec_i), .rdata_o(rdata_o), .req_o(req_o), .vec_o(vec_o),
  .pc_flag(pc_flag), .ext_flag(ext_flag), .pc_set(pc_set), .ext_set(ext_set)
);

// File: tb/tb_pcx_irq_ctrl.sv
module tb_pcx_irq_ctrl;
  localparam int NP = 11;
  localparam int G0 = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] altfn_i = '0;
  logic          ext_i = 1'b1;
  logic [1:0]    ext_mode_i = 2'b00;
  logic          gie_i = 1'b0;
  logic          wr_i = 1'b0;
  logic          addr_i = 1'b0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;
  logic          ack_i = 1'b0;
  logic [1:0]    ack_vec_i = 2'd0;
  logic          req_o;
  logic [1:0]    vec_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pcx_irq_ctrl #(.N_PINS(NP), .N_GRP0(G0), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .altfn_i(altfn_i), .ext_i(ext_i),
    .ext_mode_i(ext_mode_i), .gie_i(gie_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_i(ack_i), .ack_vec_i(ack_vec_i),
    .req_o(req_o), .vec_o(vec_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); @(negedge clk);
    wr_i = 1'b0; addr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic ack(input logic [1:0] v);
    ack_i = 1'b1; ack_vec_i = v;
    @(posedge clk); @(negedge clk);
    ack_i = 1'b0; ack_vec_i = 2'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic exp_f;
    step(3);
    rst = 1'b0;
    step(1);
    // R10 reset state
    chk("R10 rdata after reset", rdata_o, 8'h00);
    chk("R10 req after reset", {req_o, vec_o}, 3'b000);
    addr_i = 1'b1; step(1);
    chk("R10 mask after reset", rdata_o, 8'h00);
    addr_i = 1'b0;
    // R6 R10 mask write and reserved bits
    wr(1'b1, 8'hFF);
    addr_i = 1'b1; step(1);
    chk("R6 R10 mask readback", rdata_o, 8'h70);
    addr_i = 1'b0;
    gie_i = 1'b1;
    step(5);

    // R1 R2 R3 R11: sweep every pin, group enables and alternate mask
    for (int p = 0; p < NP; p++) begin
      for (int en = 0; en < 4; en++) begin
        for (int alt = 0; alt < 2; alt++) begin
          wr(1'b1, {2'b00, en[1], en[0], 4'b0000});
          wr(1'b0, 8'h60);
          altfn_i = '0;
          altfn_i[p] = alt[0];
          pin_i[p] = ~pin_i[p];
          step(4);
          exp_f = (alt == 0) && ((p < G0) ? en[0] : en[1]);
          chk($sformatf("R1 R2 R3 R11 flag pin%0d en%0d alt%0d", p, en, alt),
              rdata_o[5], exp_f);
          chk($sformatf("R9 pc request pin%0d en%0d alt%0d", p, en, alt),
              {req_o, vec_o}, exp_f ? 3'b110 : 3'b000);
        end
      end
    end
    altfn_i = '0;

    // R6 write zero keeps flag, R9 gie and group enable gating
    wr(1'b1, 8'h10);
    wr(1'b0, 8'h60);
    pin_i[0] = ~pin_i[0];
    step(4);
    chk("R1 flag set", rdata_o[5], 1'b1);
    wr(1'b0, 8'h9F);
    step(1);
    chk("R6 write zero no effect", rdata_o[5], 1'b1);
    gie_i = 1'b0; step(2);
    chk("R9 gie low blocks req", {req_o, vec_o}, 3'b000);
    gie_i = 1'b1; step(2);
    chk("R9 gie high req", {req_o, vec_o}, 3'b110);
    wr(1'b1, 8'h00); step(2);
    chk("R9 no group enable no req", {req_o, vec_o}, 3'b000);
    chk("R9 flag kept", rdata_o[5], 1'b1);
    wr(1'b1, 8'h10);
    ack(2'd2); step(1);
    chk("R7 ack clears pc flag", {rdata_o[5], req_o}, 2'b00);

    // R8 set wins over same-cycle clear, with control case
    for (int tgl = 0; tgl < 2; tgl++) begin
      pin_i[1] = ~pin_i[1];
      step(4);
      if (tgl == 1) pin_i[1] = ~pin_i[1];
      @(posedge clk); @(posedge clk); @(negedge clk);
      wr_i = 1'b1; addr_i = 1'b0; wdata_i = 8'h20;
      @(posedge clk); @(negedge clk);
      wr_i = 1'b0; wdata_i = '0;
      step(1);
      chk($sformatf("R8 set vs clear toggle%0d", tgl), rdata_o[5], tgl[0]);
      step(3);
    end
    wr(1'b0, 8'h60);

    // R4 edge modes, R7 ack of vector 1
    wr(1'b1, 8'h40);
    for (int m = 1; m < 4; m++) begin
      for (int r = 0; r < 2; r++) begin
        ext_mode_i = m[1:0];
        ext_i = (r == 1) ? 1'b0 : 1'b1;
        step(5);
        wr(1'b0, 8'h40);
        ext_i = ~ext_i;
        step(4);
        exp_f = (m == 1) || (m == 2 && r == 0) || (m == 3 && r == 1);
        chk($sformatf("R4 ext flag mode%0d rise%0d", m, r), rdata_o[6], exp_f);
        chk($sformatf("R9 ext req mode%0d rise%0d", m, r),
            {req_o, vec_o}, exp_f ? 3'b101 : 3'b000);
        if (exp_f) begin
          ack(2'd1); step(1);
          chk($sformatf("R7 ack clears ext mode%0d", m), {rdata_o[6], req_o}, 2'b00);
        end
      end
    end

    // R9 both pending: vector 1 first
    wr(1'b1, 8'h50);
    ext_mode_i = 2'b11; ext_i = 1'b0; step(5);
    wr(1'b0, 8'h60);
    ext_i = 1'b1; pin_i[2] = ~pin_i[2];
    step(4);
    chk("R9 ext over pc", {req_o, vec_o}, 3'b101);
    ack(2'd1); step(1);
    chk("R9 pc after ext ack", {req_o, vec_o}, 3'b110);

    // R5 level mode forces flag and uses input level
    wr(1'b0, 8'h60);
    ext_i = 1'b0; step(4);
    chk("R4 rise mode flag before level", rdata_o[6], 1'b0);
    ext_i = 1'b1; step(4);
    chk("R4 rise flag set", rdata_o[6], 1'b1);
    ext_mode_i = 2'b00; step(2);
    chk("R5 level mode clears flag", rdata_o[6], 1'b0);
    wr(1'b1, 8'h40);
    step(4);
    chk("R5 level high no req", {req_o, vec_o}, 3'b000);
    ext_i = 1'b0; step(4);
    chk("R5 level low req", {req_o, vec_o}, 3'b101);
    chk("R5 level flag zero", rdata_o[6], 1'b0);
    ext_i = 1'b1; step(4);
    chk("R5 level released", {req_o, vec_o}, 3'b000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule